// File: doc/BRIEF.md
# Keyed Register Write Guard

This block stands between a single-cycle memory-mapped write bus and a small set of configuration registers, and decides which writes may land. Two independent guards are provided. A bank of general configuration registers (the protected section) only takes writes while a section-wide gate is open. Software opens the gate by writing a 32-bit magic word to a dedicated gate register. The gate closes again as soon as any other word is written there. It also closes by itself once the section has seen no write for a programmable number of consecutive cycles.

A separate switch-control register carries its own guard. Every write to it must hold a key byte in the top eight data bits, and a write with the wrong key is dropped. Its nine control bits drive eight analog switch controls (1 = closed, 0 = open) and one supply-source select. The key byte is never stored and always reads back as zero.

Reads are combinational from a separate read address. Byte addresses (default 8 bits) are: gate register 0x00, switch-control register 0x04, and section register i at 0x10 + 4*i.

Top module: `cfg_guard`

## Requirements
- R1: After reset `locked` is 1, every section register and all switch-control bits are 0.
- R2: Writing 0xC5AF6927 to address 0x00 makes `locked` 0 from the next cycle and clears the idle count.
- R3: Writing any other value to address 0x00, the value 0x00000000 included, makes `locked` 1 from the next cycle.
- R4: A write to a section register while `locked` is 1 leaves every section register unchanged.
- R5: A write to section register i while `locked` is 0 stores the full 32-bit data word, visible on `sec_regs[32*i +: 32]` from the next cycle.
- R6: While unlocked, after 32 consecutive clock edges with no section write (IDLE_LIMIT = 32), `locked` becomes 1. A section write at the 32nd edge is still accepted.
- R7: Each accepted section write restarts the idle count. Writes to the switch-control register or to unmapped addresses do not restart it.
- R8: A write to address 0x04 whose data bits [31:24] equal 0x5A stores data bits [8:0], whatever the state of `locked`.
- R9: A write to address 0x04 with any other value in bits [31:24] leaves the switch-control bits unchanged.
- R10: Reads return the section register contents at their addresses. Address 0x04 returns the nine control bits in [8:0] and zero in [31:9]. Address 0x00 reads as 0.
- R11: `supply_sel` is stored control bit 8 and `sw_closed[7:0]` are stored control bits [7:0].
- R12: An access whose address has nonzero bits [1:0], or that decodes to no register, writes nothing, does not touch the idle count and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Combinational read data |
| locked | output | 1 | 1 while the section gate is closed |
| sec_regs | output | 32*N_SEC | Section register contents, register i in bits [32*i +: 32] |
| supply_sel | output | 1 | Supply-source select, control bit 8 |
| sw_closed | output | 8 | Switch controls, 1 = closed |

## Verification
The gate is driven with the exact magic word, with near-miss and zero words, and with section writes that land before, exactly at and after the 32-cycle idle boundary. These patterns separate an off-by-one timer and a timer restarted by the wrong accesses from a correct one. The switch-control register is written with the right key, with wrong keys and with ones in the unstored middle bits, which shows whether the key is checked and whether the key byte is stored. Long random mixes with idle streaks cross every guard with every lock state, and a random read of a mapped or unmapped address follows each cycle.

// File: rtl/cfg_guard_pkg.sv
`timescale 1ns/1ps
package cfg_guard_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned KEY_LSB  = 24;
    localparam int unsigned CTRL_W   = 9;

    localparam logic [DATA_W-1:0] OPEN_WORD  = 32'hC5AF_6927;
    localparam logic [DATA_W-1:0] CLOSE_WORD = 32'h0000_0000;
    localparam logic [7:0]        WR_KEY     = 8'h5A;

    typedef struct packed {
        logic       supply_sel;
        logic [7:0] sw_closed;
    } ctrl_t;

endpackage

// File: rtl/cfg_guard_lock.sv
`timescale 1ns/1ps
module cfg_guard_lock #(
    parameter int unsigned IDLE_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_wr,
    input  logic close_wr,
    input  logic sec_wr,
    output logic locked
);
    localparam int unsigned CNT_W = (IDLE_LIMIT > 1) ? $clog2(IDLE_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(IDLE_LIMIT - 1);

    typedef struct packed {
        logic             locked;
        logic [CNT_W-1:0] idle;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (open_wr) begin
            st_d.locked = 1'b0;
            st_d.idle   = '0;
        end else if (close_wr) begin
            st_d.locked = 1'b1;
            st_d.idle   = '0;
        end else if (!st_q.locked) begin
            if (sec_wr) begin
                st_d.idle = '0;
            end else if (st_q.idle == LAST_IDLE) begin
                st_d.locked = 1'b1;
                st_d.idle   = '0;
            end else begin
                st_d.idle = st_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{locked: 1'b1, idle: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

endmodule

// File: rtl/cfg_guard_bank.sv
`timescale 1ns/1ps
module cfg_guard_bank
    import cfg_guard_pkg::*;
#(
    parameter int unsigned N_SEC = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_go,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [N_SEC-1:0][DATA_W-1:0] regs
);
    typedef struct packed {
        logic [N_SEC-1:0][DATA_W-1:0] r;
    } bank_st_t;

    bank_st_t        bank_d, bank_q;
    logic [N_SEC-1:0] hit;

    for (genvar i = 0; i < N_SEC; i++) begin : g_hit
        assign hit[i] = wr_go && (wr_idx == IDX_W'(i));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N_SEC; i++) begin
            if (hit[i]) begin
                bank_d.r[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs = bank_q.r;

endmodule

// File: rtl/cfg_guard_keyed.sv
`timescale 1ns/1ps
module cfg_guard_keyed
    import cfg_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [7:0]        wr_key,
    input  logic [CTRL_W-1:0] wr_bits,
    output ctrl_t             ctrl
);
    typedef struct packed {
        ctrl_t ctrl;
    } key_st_t;

    key_st_t key_d, key_q;

    always_comb begin
        key_d = key_q;
        if (wr_hit && (wr_key == WR_KEY)) begin
            key_d.ctrl = ctrl_t'(wr_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else begin
            key_q <= key_d;
        end
    end

    assign ctrl = key_q.ctrl;

endmodule

// File: rtl/cfg_guard.sv
`timescale 1ns/1ps
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned N_SEC         = 4,
    parameter int unsigned SEC_BASE_WORD = 4,
    parameter int unsigned IDLE_LIMIT    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [31:0]             wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [31:0]             rd_data,
    output logic                    locked,
    output logic [32*N_SEC-1:0]     sec_regs,
    output logic                    supply_sel,
    output logic [7:0]              sw_closed
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned IDX_W  = (N_SEC > 1) ? $clog2(N_SEC) : 1;
    localparam logic [WORD_W-1:0] W_GATE  = WORD_W'(0);
    localparam logic [WORD_W-1:0] W_KEYED = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_SEC   = WORD_W'(SEC_BASE_WORD);
    localparam logic [WORD_W-1:0] W_NSEC  = WORD_W'(N_SEC);

    // write decode
    logic [WORD_W-1:0] wr_word, wr_off;
    logic              wr_ok, gate_wr, open_wr, close_wr, keyed_wr, sec_wr;

    always_comb begin
        wr_word  = wr_addr[ADDR_W-1:2];
        wr_off   = wr_word - W_SEC;
        wr_ok    = wr_en && (wr_addr[1:0] == 2'b00);
        gate_wr  = wr_ok && (wr_word == W_GATE);
        open_wr  = gate_wr && (wr_data == OPEN_WORD);
        close_wr = gate_wr && (wr_data != OPEN_WORD);
        keyed_wr = wr_ok && (wr_word == W_KEYED);
        sec_wr   = wr_ok && (wr_word >= W_SEC) && (wr_off < W_NSEC);
    end

    logic                         lock_q;
    logic [N_SEC-1:0][DATA_W-1:0] sec_q;
    ctrl_t                        ctrl_q;

    cfg_guard_lock #(
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_wr  (open_wr),
        .close_wr (close_wr),
        .sec_wr   (sec_wr),
        .locked   (lock_q)
    );

    cfg_guard_bank #(
        .N_SEC (N_SEC),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (sec_wr && !lock_q),
        .wr_idx  (wr_off[IDX_W-1:0]),
        .wr_data (wr_data),
        .regs    (sec_q)
    );

    cfg_guard_keyed u_keyed (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (keyed_wr),
        .wr_key  (wr_data[KEY_LSB +: 8]),
        .wr_bits (wr_data[CTRL_W-1:0]),
        .ctrl    (ctrl_q)
    );

    // read decode
    logic [WORD_W-1:0] rd_word, rd_off;
    logic              rd_ok, rd_sec;

    always_comb begin
        rd_word = rd_addr[ADDR_W-1:2];
        rd_off  = rd_word - W_SEC;
        rd_ok   = (rd_addr[1:0] == 2'b00);
        rd_sec  = rd_ok && (rd_word >= W_SEC) && (rd_off < W_NSEC);
        rd_data = '0;
        if (rd_ok && (rd_word == W_KEYED)) begin
            rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        end else if (rd_sec) begin
            rd_data = sec_q[rd_off[IDX_W-1:0]];
        end
    end

    assign locked     = lock_q;
    assign sec_regs   = sec_q;
    assign supply_sel = ctrl_q.supply_sel;
    assign sw_closed  = ctrl_q.sw_closed;

endmodule

// File: rtl/cfg_guard_chk.sv
`timescale 1ns/1ps
module cfg_guard_chk
    import cfg_guard_pkg::*;
#(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned N_SEC         = 4,
    parameter int unsigned SEC_BASE_WORD = 4,
    parameter int unsigned IDLE_LIMIT    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [31:0]         wr_data,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [31:0]         rd_data,
    input logic                locked,
    input logic [32*N_SEC-1:0] sec_regs,
    input logic                supply_sel,
    input logic [7:0]          sw_closed
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] ww, rw;
    logic wok, open_w, close_w, key_ok_w, sec_w, rd_keyed, rd_gate;
    int   idle_cnt;

    always_comb begin
        ww       = wr_addr[ADDR_W-1:2];
        rw       = rd_addr[ADDR_W-1:2];
        wok      = wr_en && (wr_addr[1:0] == 2'b00);
        open_w   = wok && (ww == WORD_W'(0)) && (wr_data == OPEN_WORD);
        close_w  = wok && (ww == WORD_W'(0)) && (wr_data != OPEN_WORD);
        key_ok_w = wok && (ww == WORD_W'(1)) && (wr_data[31:24] == WR_KEY);
        sec_w    = wok && (ww >= WORD_W'(SEC_BASE_WORD))
                       && (ww < WORD_W'(SEC_BASE_WORD + N_SEC));
        rd_keyed = (rd_addr[1:0] == 2'b00) && (rw == WORD_W'(1));
        rd_gate  = (rd_addr[1:0] == 2'b00) && (rw == WORD_W'(0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= 0;
        end else if (open_w || close_w || locked || sec_w) begin
            idle_cnt <= 0;
        end else begin
            idle_cnt <= idle_cnt + 1;
        end
    end

    AST_OPEN_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        open_w |=> !locked); // R2
    AST_BAD_WORD_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        close_w |=> locked); // R3
    AST_SEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec_w && !locked) |=> $stable(sec_regs)); // R4
    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (idle_cnt < IDLE_LIMIT)); // R6
    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !key_ok_w |=> $stable({supply_sel, sw_closed})); // R9
    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_keyed |-> (rd_data[31:9] == 23'd0)); // R10
    AST_GATE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gate |-> (rd_data == 32'd0)); // R10

endmodule

bind cfg_guard cfg_guard_chk #(
    .ADDR_W        (ADDR_W),
    .N_SEC         (N_SEC),
    .SEC_BASE_WORD (SEC_BASE_WORD),
    .IDLE_LIMIT    (IDLE_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .locked     (locked),
    .sec_regs   (sec_regs),
    .supply_sel (supply_sel),
    .sw_closed  (sw_closed)
);

// File: tb/tb_cfg_guard.sv
`timescale 1ns/1ps
module tb_cfg_guard;
    localparam int N_SEC = 4;
    localparam int LIMIT = 32;
    localparam logic [31:0] OPEN = 32'hC5AF_6927;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        locked;
    logic [32*N_SEC-1:0] sec_regs;
    logic        supply_sel;
    logic [7:0]  sw_closed;

    always #5 clk = ~clk;

    cfg_guard dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .locked(locked), .sec_regs(sec_regs), .supply_sel(supply_sel),
        .sw_closed(sw_closed)
    );

    // reference state
    logic        m_locked;
    int          m_idle;
    logic [31:0] m_sec [N_SEC];
    logic [8:0]  m_ctrl;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        int w;
        w = int'(a[7:2]);
        if (a[1:0] != 2'b00) return 32'd0;
        if (w == 1) return {23'd0, m_ctrl};
        if (w >= 4 && w < 4 + N_SEC) return m_sec[w-4];
        return 32'd0;
    endfunction

    task automatic model_edge(logic we, logic [7:0] a, logic [31:0] d);
        int  w;
        bit  ok, sec;
        w   = int'(a[7:2]);
        ok  = we && (a[1:0] == 2'b00);
        sec = ok && w >= 4 && w < 4 + N_SEC;
        if (ok && w == 1 && d[31:24] == 8'h5A) m_ctrl = d[8:0];
        if (ok && w == 0) begin
            m_locked = (d != OPEN);
            m_idle   = 0;
        end else if (!m_locked) begin
            if (sec) begin
                m_sec[w-4] = d;
                m_idle     = 0;
            end else if (m_idle == LIMIT - 1) begin
                m_locked = 1'b1;
                m_idle   = 0;
            end else begin
                m_idle++;
            end
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "locked", {31'd0, locked}, {31'd0, m_locked});
        for (int i = 0; i < N_SEC; i++)
            check(tag, $sformatf("sec_regs[%0d]", i), sec_regs[32*i +: 32], m_sec[i]);
        check(tag, "supply_sel", {31'd0, supply_sel}, {31'd0, m_ctrl[8]});
        check(tag, "sw_closed", {24'd0, sw_closed}, {24'd0, m_ctrl[7:0]});
        check(tag, $sformatf("rd_data@%h", rd_addr), rd_data, exp_rd(rd_addr));
    endtask

    task automatic step(logic we, logic [7:0] a, logic [31:0] d, logic [7:0] ra, string tag);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
        @(posedge clk);
        model_edge(we, a, d);
        #2;
        check_all(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 32'd0, 8'h10, tag);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        m_locked = 1'b1; m_idle = 0; m_ctrl = '0;
        for (int i = 0; i < N_SEC; i++) m_sec[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        check("R1", "locked", {31'd0, locked}, 32'd1);
        check("R1", "sec_regs", sec_regs[31:0] | sec_regs[63:32] | sec_regs[95:64] | sec_regs[127:96], 32'd0);
        check("R1", "ctrl", {23'd0, supply_sel, sw_closed}, 32'd0);

        // R4 writes while locked are dropped
        step(1, 8'h10, 32'hDEAD_BEEF, 8'h10, "R4");
        step(1, 8'h1C, 32'h1234_5678, 8'h1C, "R4");
        check("R4", "sec0 after locked write", sec_regs[31:0], 32'd0);

        // R8 R9 R10 R11 keyed register
        step(1, 8'h04, {8'h5B, 15'h0, 9'h0F0}, 8'h04, "R9");
        check("R9", "ctrl after wrong key", {23'd0, supply_sel, sw_closed}, 32'd0);
        step(1, 8'h04, {8'h5A, 15'h7FFF, 9'h1A5}, 8'h04, "R8");
        check("R10", "keyed readback", rd_data, 32'h0000_01A5);
        check("R11", "supply_sel", {31'd0, supply_sel}, 32'd1);
        check("R11", "sw_closed", {24'd0, sw_closed}, 32'h0000_00A5);
        step(1, 8'h04, {8'h00, 15'h0, 9'h003}, 8'h04, "R9");
        check("R9", "ctrl after zero key", rd_data, 32'h0000_01A5);

        // R2 R5 R10 unlock and write
        step(1, 8'h00, OPEN, 8'h00, "R2");
        check("R2", "locked after open word", {31'd0, locked}, 32'd0);
        check("R10", "gate reads zero", rd_data, 32'd0);
        step(1, 8'h14, 32'hCAFE_F00D, 8'h14, "R5");
        check("R5", "sec1 readback", rd_data, 32'hCAFE_F00D);

        // R12 unaligned and unmapped accesses
        step(1, 8'h11, 32'h1111_1111, 8'h11, "R12");
        check("R12", "unaligned read", rd_data, 32'd0);
        check("R12", "sec0 after unaligned write", sec_regs[31:0], 32'd0);
        step(1, 8'h40, 32'h2222_2222, 8'h40, "R12");

        // R6 timeout exactly at the limit
        step(1, 8'h00, OPEN, 8'h10, "R6");
        idle(LIMIT - 1, "R6");
        check("R6", "still open before limit", {31'd0, locked}, 32'd0);
        idle(1, "R6");
        check("R6", "locked at limit", {31'd0, locked}, 32'd1);

        // R6 R7 write at the last edge restarts the count
        step(1, 8'h00, OPEN, 8'h10, "R7");
        idle(LIMIT - 1, "R7");
        step(1, 8'h18, 32'hA5A5_0001, 8'h18, "R6");
        check("R6", "write at last edge accepted", rd_data, 32'hA5A5_0001);
        idle(LIMIT - 2, "R7");
        step(1, 8'h04, {8'h5A, 24'h000055}, 8'h04, "R7");
        check("R7", "open before restarted limit", {31'd0, locked}, 32'd0);
        idle(1, "R7");
        check("R7", "keyed write did not restart count", {31'd0, locked}, 32'd1);

        // R3 bad words lock at once
        step(1, 8'h00, OPEN, 8'h10, "R2");
        step(1, 8'h00, OPEN ^ 32'h1, 8'h10, "R3");
        check("R3", "near-miss word locks", {31'd0, locked}, 32'd1);
        step(1, 8'h00, OPEN, 8'h10, "R2");
        step(1, 8'h00, 32'd0, 8'h10, "R3");
        check("R3", "zero word locks", {31'd0, locked}, 32'd1);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int op;
            logic [7:0] ra, wa;
            op = int'($urandom_range(0, 15));
            ra = ($urandom_range(0, 7) == 0) ? 8'($urandom) : {3'd0, 3'($urandom_range(0, 7)), 2'b00};
            wa = {3'd0, 3'($urandom_range(4, 7)), 2'b00};
            case (op)
                0, 1:  step(1, 8'h00, OPEN, ra, "R2");
                2:     step(1, 8'h00, $urandom, ra, "R3");
                3:     step(1, 8'h04, {8'h5A, 24'($urandom)}, ra, "R8");
                4:     step(1, 8'h04, $urandom, ra, "R9");
                5, 6, 7, 8, 9: step(1, wa, $urandom, ra, "R5");
                10, 11: step(0, wa, $urandom, ra, "R10");
                12:    step(1, 8'($urandom), $urandom, ra, "R12");
                13:    step(1, 8'h00, 32'd0, ra, "R3");
                default: begin
                    for (int j = 0; j < int'($urandom_range(25, 40)); j++)
                        step(0, 8'h00, 32'd0, ra, "R6");
                end
            endcase
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule